// File: doc/BRIEF.md
# Shared Time-Base and Watchdog Timer

This block turns a 32768 Hz clock enable into two timing services that share one counter. A prescaler of 2^PRE_W ticks feeds a chain of further divide-by-two stages. A 3-bit code picks one bit of that chain as a time-base square wave of 1, 2, 4, 8, 16, 32, 64 or 128 Hz. A divide-by-four watchdog stage counts completed periods of the chosen wave. When it wraps, it raises a sticky timeout flag.

Decoded command strobes drive the block, one per action: switch the timer on or off, switch the watchdog on or off, switch the interrupt on or off, clear the timer chain, clear the watchdog stage, and write a new frequency code. The interrupt pin is active low and open drain. It is modelled as a single output that, when high, means "pull the pin low". A new frequency code is held pending and takes over only at the next prescaler wrap. This keeps a half-finished watchdog period from being counted twice or skipped.

Top module: `tick_wdog`

## Requirements
- R1: After reset the timer, watchdog and interrupt enables are off, `irq_pull_low` is 0, the chain and the watchdog stage are zero, and the active frequency code is 0.
- R2: Each cycle with `tick_en` high advances one chain of CHAIN_W = PRE_W + 2^SEL_W - 1 bits. Code c selects chain bit CHAIN_W-1-c as the time-base wave. With the default PRE_W=8 and a 32768 Hz tick, codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128 Hz.
- R3: With the interrupt and timer enabled and no timeout flag, `irq_pull_low` equals the selected chain bit. It is 0 in the first half of each period counted from a zero chain and 1 in the second half.
- R4: With the watchdog enabled, a period completes on a tick where the selected chain bit and every bit below it are all 1. The fourth completion after a watchdog clear sets the timeout flag. A disabled watchdog neither counts nor sets the flag.
- R5: The timeout flag stays set until a watchdog clear or an interrupt-off strobe. While the flag is set and the interrupt is enabled, `irq_pull_low` is 1 whatever the wave does.
- R6: The enables and clears are independent of each other. Timer clear zeroes only the chain. Watchdog clear zeroes only the watchdog stage and flag. Watchdog-off does not release a pending flag.
- R7: `sel_we` captures `sel_code` as a pending code. The active code takes the pending value only on a prescaler wrap, which is a tick with the low PRE_W chain bits all 1.
- R8: When a strobe pair lands in the same cycle, off beats on, a timer clear beats a tick, and a watchdog clear beats a timeout.
- R9: While the interrupt is disabled, `irq_pull_low` is 0.
- R10: In cycles with `tick_en` low the chain, the watchdog stage and the active code hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz time-base clock enable |
| tmr_on | input | 1 | Timer enable strobe |
| tmr_off | input | 1 | Timer disable strobe |
| tmr_clr | input | 1 | Clear the shared divider chain |
| wdt_on | input | 1 | Watchdog enable strobe |
| wdt_off | input | 1 | Watchdog disable strobe |
| wdt_clr | input | 1 | Clear the watchdog stage and flag |
| irq_on | input | 1 | Interrupt output enable strobe |
| irq_off | input | 1 | Interrupt output disable strobe, also releases the flag |
| sel_we | input | 1 | Write strobe for the frequency code |
| sel_code | input | SEL_W | Frequency code, 0 slowest to 7 fastest |
| irq_pull_low | output | 1 | High when the open-drain interrupt pin is driven low |

## Verification
The bench zeroes the chain and the watchdog together, so it knows the tick count exactly and can sample just before and just after each wave edge and timeout. A design that took a new code at once, instead of at the prescaler wrap, shows the wrong wave level while the tick is held off. One whose chain clear also reset the watchdog stage times out a full two periods late. Same-cycle strobe collisions are driven on purpose. A design where on beats off leaves the wave visible. One where a timeout beats a clear raises the interrupt at the fourth period. A flag that is not sticky, or that yields to the wave, drops the pin once the square wave goes low.

// File: rtl/tick_wdog_pkg.sv
package tick_wdog_pkg;

    // divide-by-four watchdog stage
    localparam int unsigned WD_STAGE_W = 2;

    // one on/off/clear strobe group
    typedef struct packed {
        logic on;
        logic off;
        logic clr;
    } ctl_cmd_t;

    // registered enable set
    typedef struct packed {
        logic tmr;
        logic wdt;
        logic irq;
    } en_set_t;

    // off has priority over on
    function automatic logic next_enable(input logic cur, input ctl_cmd_t c);
        return c.off ? 1'b0 : (c.on ? 1'b1 : cur);
    endfunction

endpackage

// File: rtl/tick_wdog_chain.sv
module tick_wdog_chain #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             clr,
    input  logic [SEL_W-1:0] act_sel,
    output logic             wave,
    output logic             period_done,
    output logic             pre_wrap
);
    localparam int unsigned NCODE   = 1 << SEL_W;
    localparam int unsigned CHAIN_W = PRE_W + NCODE - 1;
    localparam int unsigned IDX_W   = $clog2(CHAIN_W);

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] low_mask;
    logic [IDX_W-1:0]   tap_idx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            chain_q <= '0;
        end else if (tick_en) begin
            chain_q <= chain_q + 1'b1;
        end
    end

    always_comb begin
        tap_idx     = IDX_W'(CHAIN_W - 1) - IDX_W'(act_sel);
        low_mask    = {CHAIN_W{1'b1}} >> act_sel;
        wave        = chain_q[tap_idx];
        period_done = tick_en && ((chain_q & low_mask) == low_mask);
        pre_wrap    = tick_en && (&chain_q[PRE_W-1:0]);
    end

    AST_CLR_EMPTIES_CHAIN: assert property (@(posedge clk) disable iff (rst)
        clr |=> (chain_q == '0)); // R6

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !clr) |=> $stable(chain_q)); // R10

endmodule

// File: rtl/tick_wdog_sel.sv
module tick_wdog_sel #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             pre_wrap,
    output logic [SEL_W-1:0] act_sel
);
    logic [SEL_W-1:0] pend_q;
    logic [SEL_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (sel_we) begin
                pend_q <= sel_code;
            end
            if (pre_wrap) begin
                act_q <= pend_q;
            end
        end
    end

    assign act_sel = act_q;

    AST_SEL_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(pre_wrap)); // R7

endmodule

// File: rtl/tick_wdog_watch.sv
module tick_wdog_watch
    import tick_wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wdt_en,
    input  logic clr,
    input  logic release_req,
    input  logic period_done,
    output logic flag
);
    logic [WD_STAGE_W-1:0] stage_q;
    logic                  flag_q;
    logic                  count_ev;

    assign count_ev = wdt_en && period_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (clr) begin
                stage_q <= '0;
            end else if (count_ev) begin
                stage_q <= stage_q + 1'b1;
            end
            if (clr || release_req) begin
                flag_q <= 1'b0;
            end else if (count_ev && (&stage_q)) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign flag = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr && !release_req) |=> flag_q); // R5

    AST_FLAG_NEEDS_WDT: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(wdt_en)); // R4

    AST_CLEAR_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag_q); // R8

endmodule

// File: rtl/tick_wdog_ctrl.sv
module tick_wdog_ctrl
    import tick_wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_cmd_t tmr_cmd,
    input  ctl_cmd_t wdt_cmd,
    input  ctl_cmd_t irq_cmd,
    output en_set_t  en
);
    en_set_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q.tmr <= next_enable(en_q.tmr, tmr_cmd);
            en_q.wdt <= next_enable(en_q.wdt, wdt_cmd);
            en_q.irq <= next_enable(en_q.irq, irq_cmd);
        end
    end

    assign en = en_q;

    AST_TMR_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        tmr_cmd.off |=> !en_q.tmr); // R8

    AST_WDT_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        wdt_cmd.off |=> !en_q.wdt); // R8

    AST_IRQ_KEEPS_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!irq_cmd.on && !irq_cmd.off) |=> $stable(en_q.irq)); // R6

endmodule

// File: rtl/tick_wdog.sv
module tick_wdog
    import tick_wdog_pkg::*;
#(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             tmr_on,
    input  logic             tmr_off,
    input  logic             tmr_clr,
    input  logic             wdt_on,
    input  logic             wdt_off,
    input  logic             wdt_clr,
    input  logic             irq_on,
    input  logic             irq_off,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_code,
    output logic             irq_pull_low
);
    ctl_cmd_t         tmr_cmd;
    ctl_cmd_t         wdt_cmd;
    ctl_cmd_t         irq_cmd;
    en_set_t          en;
    logic [SEL_W-1:0] act_sel;
    logic             wave;
    logic             period_done;
    logic             pre_wrap;
    logic             wd_flag;

    assign tmr_cmd = '{on: tmr_on, off: tmr_off, clr: tmr_clr};
    assign wdt_cmd = '{on: wdt_on, off: wdt_off, clr: wdt_clr};
    assign irq_cmd = '{on: irq_on, off: irq_off, clr: 1'b0};

    tick_wdog_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tmr_cmd (tmr_cmd),
        .wdt_cmd (wdt_cmd),
        .irq_cmd (irq_cmd),
        .en      (en)
    );

    tick_wdog_sel #(.SEL_W(SEL_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (sel_we),
        .sel_code (sel_code),
        .pre_wrap (pre_wrap),
        .act_sel  (act_sel)
    );

    tick_wdog_chain #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_chain (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .clr         (tmr_cmd.clr),
        .act_sel     (act_sel),
        .wave        (wave),
        .period_done (period_done),
        .pre_wrap    (pre_wrap)
    );

    tick_wdog_watch u_watch (
        .clk         (clk),
        .rst         (rst),
        .wdt_en      (en.wdt),
        .clr         (wdt_cmd.clr),
        .release_req (irq_cmd.off),
        .period_done (period_done),
        .flag        (wd_flag)
    );

    // flag takes priority over the time-base wave
    assign irq_pull_low = en.irq && (wd_flag || (en.tmr && wave));

    AST_IRQ_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_off |=> !irq_pull_low); // R9

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_pull_low); // R1

endmodule

// File: tb/tick_wdog_tb_top.sv
module tick_wdog_tb_top;
    localparam int unsigned PRE_W = 2;
    localparam int unsigned SEL_W = 3;

    localparam logic [8:0] M_TON  = 9'h100;
    localparam logic [8:0] M_TOFF = 9'h080;
    localparam logic [8:0] M_TCLR = 9'h040;
    localparam logic [8:0] M_WON  = 9'h020;
    localparam logic [8:0] M_WOFF = 9'h010;
    localparam logic [8:0] M_WCLR = 9'h008;
    localparam logic [8:0] M_ION  = 9'h004;
    localparam logic [8:0] M_IOFF = 9'h002;
    localparam logic [8:0] M_SEL  = 9'h001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic tmr_on = 0, tmr_off = 0, tmr_clr = 0;
    logic wdt_on = 0, wdt_off = 0, wdt_clr = 0;
    logic irq_on = 0, irq_off = 0, sel_we = 0;
    logic [SEL_W-1:0] sel_code = '0;
    logic irq_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tick_wdog #(.PRE_W(PRE_W), .SEL_W(SEL_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .tmr_on       (tmr_on),
        .tmr_off      (tmr_off),
        .tmr_clr      (tmr_clr),
        .wdt_on       (wdt_on),
        .wdt_off      (wdt_off),
        .wdt_clr      (wdt_clr),
        .irq_on       (irq_on),
        .irq_off      (irq_off),
        .sel_we       (sel_we),
        .sel_code     (sel_code),
        .irq_pull_low (irq_pull_low)
    );

    task automatic chk(input logic exp, input string what);
        checks++;
        if (irq_pull_low !== exp) begin
            errors++;
            $display("FAIL %s irq_pull_low=%0b expected=%0b", what, irq_pull_low, exp);
        end
    endtask

    // drive strobes for one clock edge; starts and ends at a falling edge
    task automatic cmd(input logic [8:0] m, input logic [SEL_W-1:0] code = '0);
        {tmr_on, tmr_off, tmr_clr, wdt_on, wdt_off, wdt_clr, irq_on, irq_off, sel_we} = m;
        sel_code = code;
        @(negedge clk);
        {tmr_on, tmr_off, tmr_clr, wdt_on, wdt_off, wdt_clr, irq_on, irq_off, sel_we} = '0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write a code and let a prescaler wrap pass (tick running)
    task automatic set_code(input logic [SEL_W-1:0] c);
        cmd(M_SEL, c);
        run(1 << PRE_W);
    endtask

    // zero chain and watchdog stage together: afterwards tick count k = 0
    task automatic sync_zero();
        cmd(M_TCLR | M_WCLR);
    endtask

    task automatic t_reset_default();
        chk(1'b0, "R1 reset output");
        cmd(M_TON | M_ION);
        sync_zero();
        run(255);
        chk(1'b0, "R1 R3 code0 first half");
        run(1);
        chk(1'b1, "R1 R2 code0 second half");
    endtask

    task automatic t_wave_codes();
        set_code(3'd3);
        sync_zero();
        run(31);  chk(1'b0, "R2 code3 k31");
        run(1);   chk(1'b1, "R3 code3 k32");
        run(31);  chk(1'b1, "R3 code3 k63");
        run(1);   chk(1'b0, "R2 code3 k64");
        set_code(3'd7);
        sync_zero();
        run(1);   chk(1'b0, "R2 code7 k1");
        run(1);   chk(1'b1, "R2 code7 k2");
        run(2);   chk(1'b0, "R2 code7 k4");
    endtask

    task automatic t_watchdog();
        cmd(M_TOFF | M_WON);
        set_code(3'd5);
        sync_zero();
        run(63);  chk(1'b0, "R4 before fourth period");
        run(1);   chk(1'b1, "R4 timeout at fourth period");
        run(100); chk(1'b1, "R5 flag sticky");
        cmd(M_WCLR);
        chk(1'b0, "R5 watchdog clear releases");
        sync_zero();
        run(64);  chk(1'b1, "R4 timeout again");
        cmd(M_IOFF);
        chk(1'b0, "R5 irq off releases");
        cmd(M_ION);
        chk(1'b0, "R5 flag gone after irq off");
    endtask

    task automatic t_priority();
        cmd(M_TON);
        sync_zero();
        run(4);   chk(1'b0, "R3 wave low k4");
        run(4);   chk(1'b1, "R3 wave high k8");
        run(56);  chk(1'b1, "R5 flag over low wave k64");
        run(16);  chk(1'b1, "R5 flag over low wave k80");
        cmd(M_WOFF | M_TOFF);
        chk(1'b1, "R6 watchdog off keeps flag");
        cmd(M_WCLR);
        chk(1'b0, "R6 watchdog clear after off");
        set_code(3'd7);
        sync_zero();
        run(100); chk(1'b0, "R4 disabled watchdog silent");
    endtask

    task automatic t_independence();
        cmd(M_WON);
        set_code(3'd5);
        sync_zero();
        run(40);
        cmd(M_TCLR);
        run(31);  chk(1'b0, "R6 timer clear keeps stage k31");
        run(1);   chk(1'b1, "R6 timer clear keeps stage k32");
        cmd(M_WOFF | M_WCLR | M_TON);
        set_code(3'd7);
        sync_zero();
        run(1);
        cmd(M_WCLR);
        chk(1'b1, "R6 watchdog clear keeps chain");
    endtask

    task automatic t_select_and_hold();
        sync_zero();
        run(2);
        tick_en = 1'b0;
        run(6);   chk(1'b1, "R10 chain holds without tick");
        cmd(M_SEL, 3'd0);
        chk(1'b1, "R7 code pending not active");
        tick_en = 1'b1;
        run(1);   chk(1'b1, "R7 old code before wrap");
        run(1);   chk(1'b0, "R7 new code after wrap");
    endtask

    task automatic t_collisions();
        sync_zero();
        run(255);
        cmd(M_TON | M_TOFF);
        chk(1'b0, "R8 off beats on");
        cmd(M_WON | M_WCLR);
        set_code(3'd7);
        sync_zero();
        run(15);  chk(1'b0, "R4 before timeout");
        cmd(M_WCLR);
        chk(1'b0, "R8 clear beats timeout");
        run(15);  chk(1'b0, "R8 restart count");
        run(1);   chk(1'b1, "R4 timeout after restart");
        cmd(M_IOFF | M_TON);
        run(1);
        chk(1'b0, "R9 irq disabled");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_default();
        t_wave_codes();
        t_watchdog();
        t_priority();
        t_independence();
        t_select_and_hold();
        t_collisions();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired irq_pull_low=%0b expected=finish", irq_pull_low);
            finish_run();
        end
    end

endmodule